// File: doc/BRIEF.md
# Dual-Direction Word Mailbox Between Two Processors

This block joins two processors, side A and side B, with a pair of one-way word queues. Side A pushes words that side B pops, and side B pushes words that side A pops. Each queue holds sixteen 32-bit words. Each side has a push port, a pop port with read data and a 16-bit control/status register. A side sees two views of the same pair of queues: its own outgoing queue (the send view) and its peer's outgoing queue (the receive view).

Software on a side turns the mailbox on with an enable bit and can flush its outgoing queue. A sticky error flag records a push into a full queue or a pop from an empty one, and software clears it by writing a one. Two single-cycle interrupt request lines go to each side. One fires when that side's outgoing queue is drained by the peer. The other fires when that side's incoming queue gets its first word. A pop from an empty queue returns the last word that side popped successfully.

Top module: `ipcmb_top`

## Requirements
- R1: Each queue holds at most 16 words and reports full exactly at 16 words. A push into a full queue is dropped without disturbing stored data and sets the sender's error flag.
- R2: The sender's send-empty/send-full bits and the receiver's receive-empty/receive-full bits for one queue always show the same occupancy.
- R3: Writing the control register with bit 3 set empties the writer's outgoing queue. The writer's send-empty bit and the peer's receive-empty bit read 1, both full bits read 0, and no interrupt fires. A push in the same cycle is lost.
- R4: A push while the sender's enable bit (bit 15) is 0 is discarded. Occupancy, flags and error flag stay unchanged.
- R5: The receive-ready interrupt of a side pulses in the cycle after a push turns its incoming queue from empty to non-empty, and only if its receive-interrupt enable (bit 10) was set.
- R6: The send-empty interrupt of a side pulses in the cycle after a pop by the peer turns its outgoing queue from non-empty to empty, and only if its send-interrupt enable (bit 2) was set.
- R7: Pop data is valid in the same cycle as the pop strobe. Popping an empty queue returns the last word that side popped (zero after reset) and sets that side's error flag.
- R8: The error flag (bit 14) clears when the control register is written with bit 14 = 1 and is unchanged when it is written with bit 14 = 0. A new error in the same cycle wins over the clear.
- R9: Interrupt requests are one-cycle pulses. A push and a pop on the same queue in one cycle keep the occupancy and raise neither interrupt.
- R10: After reset both queues are empty, all enables and error flags are 0, the interrupt lines are low and pop data reads zero.
- R11: Words come out of each queue in the order they were pushed.
- R12: Control register read layout: bit 0 send empty, bit 1 send full, bit 2 send-interrupt enable, bit 8 receive empty, bit 9 receive full, bit 10 receive-interrupt enable, bit 14 error, bit 15 enable. All other bits read 0, bit 3 included. A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_ctl_we | input | 1 | Side A control register write strobe |
| a_ctl_wdata | input | 16 | Side A control register write data |
| a_ctl_rdata | output | 16 | Side A control/status read value |
| a_tx_valid | input | 1 | Side A push strobe |
| a_tx_data | input | 32 | Side A push word |
| a_rx_take | input | 1 | Side A pop strobe |
| a_rx_data | output | 32 | Side A pop word (head or last popped word) |
| a_irq_tx_empty | output | 1 | Side A send-drained interrupt pulse |
| a_irq_rx_ready | output | 1 | Side A receive-ready interrupt pulse |
| b_ctl_we | input | 1 | Side B control register write strobe |
| b_ctl_wdata | input | 16 | Side B control register write data |
| b_ctl_rdata | output | 16 | Side B control/status read value |
| b_tx_valid | input | 1 | Side B push strobe |
| b_tx_data | input | 32 | Side B push word |
| b_rx_take | input | 1 | Side B pop strobe |
| b_rx_data | output | 32 | Side B pop word (head or last popped word) |
| b_irq_tx_empty | output | 1 | Side B send-drained interrupt pulse |
| b_irq_rx_ready | output | 1 | Side B receive-ready interrupt pulse |

## Verification
On every cycle the assertions check the occupancy bound, the emptying effect of a flush, the frozen occupancy under a disabled push and under a balanced push/pop, and the agreement of the two views of each queue. They also check that every interrupt pulse was enabled and lasts one cycle, and that the write-one clear of the error flag takes effect. Only the bench scenarios show data order across many words, the returned last-popped word on an empty read, and that an interrupt fires on exactly the right edge and on no other. The same holds for error setting on overflow and underflow and for a push lost to a simultaneous flush. The bench compares these against its own model under both directed and random traffic.

// File: rtl/ipcmb_pkg.sv
package ipcmb_pkg;
  localparam int CTL_W        = 16;
  localparam int BIT_TX_EMPTY = 0;
  localparam int BIT_TX_FULL  = 1;
  localparam int BIT_TX_IE    = 2;
  localparam int BIT_FLUSH    = 3;
  localparam int BIT_RX_EMPTY = 8;
  localparam int BIT_RX_FULL  = 9;
  localparam int BIT_RX_IE    = 10;
  localparam int BIT_ERR      = 14;
  localparam int BIT_EN       = 15;

  // Per-cycle status of one queue, shared by its sender and receiver views
  typedef struct packed {
    logic empty;
    logic full;
    logic push_ok;
    logic push_ovf;
    logic pop_ok;
    logic pop_unf;
    logic went_nempty;
    logic went_empty;
  } q_stat_t;
endpackage

// File: rtl/ipcmb_queue.sv
module ipcmb_queue
  import ipcmb_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_req,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop_req,
  input  logic                       flush,
  output logic [DW-1:0]              head,
  output logic [$clog2(DEPTH):0]     count,
  output q_stat_t                    stat
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_nxt, rd_q, rd_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          ptr_ce;
  logic          empty, full, push_ok, pop_ok;

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == CW'(DEPTH));
    push_ok = push_req & ~full;
    pop_ok  = pop_req & ~empty;

    stat.empty       = empty;
    stat.full        = full;
    stat.push_ok     = push_ok;
    stat.push_ovf    = push_req & full;
    stat.pop_ok      = pop_ok;
    stat.pop_unf     = pop_req & empty;
    stat.went_nempty = push_ok & empty & ~flush;
    stat.went_empty  = pop_ok & ~push_ok & (cnt_q == CW'(1)) & ~flush;

    wr_nxt  = wr_q;
    rd_nxt  = rd_q;
    cnt_nxt = cnt_q;
    if (flush) begin
      wr_nxt  = '0;
      rd_nxt  = '0;
      cnt_nxt = '0;
    end else begin
      if (push_ok) wr_nxt = (wr_q == LAST) ? '0 : wr_q + AW'(1);
      if (pop_ok)  rd_nxt = (rd_q == LAST) ? '0 : rd_q + AW'(1);
      cnt_nxt = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
    ptr_ce = flush | push_ok | pop_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (ptr_ce) begin
      wr_q  <= wr_nxt;
      rd_q  <= rd_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= push_data;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R1
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_req && !flush) |=> (cnt_q == CW'(DEPTH))); // R1
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0)); // R3
  AST_BALANCED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok && !flush) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/ipcmb_side.sv
module ipcmb_side
  import ipcmb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  q_stat_t          tx_stat,
  input  q_stat_t          rx_stat,
  input  logic [DW-1:0]    rx_head,
  output logic             fifo_en,
  output logic             flush,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic [DW-1:0]    rx_data,
  output logic             irq_tx_empty,
  output logic             irq_rx_ready
);
  logic          en_q, tx_ie_q, rx_ie_q, err_q;
  logic          en_nxt, tx_ie_nxt, rx_ie_nxt, err_nxt;
  logic [DW-1:0] last_q;
  logic          irq_tx_q, irq_rx_q, irq_tx_nxt, irq_rx_nxt;
  logic          cfg_ce, err_ce, last_ce, err_set;
  logic          sink_unused;

  always_comb begin
    cfg_ce    = ctl_we;
    en_nxt    = ctl_wdata[BIT_EN];
    tx_ie_nxt = ctl_wdata[BIT_TX_IE];
    rx_ie_nxt = ctl_wdata[BIT_RX_IE];

    err_set   = tx_stat.push_ovf | rx_stat.pop_unf;
    err_ce    = err_set | (ctl_we & ctl_wdata[BIT_ERR]);
    err_nxt   = err_set;

    last_ce   = rx_stat.pop_ok;

    irq_tx_nxt = tx_ie_q & tx_stat.went_empty;
    irq_rx_nxt = rx_ie_q & rx_stat.went_nempty;

    flush   = ctl_we & ctl_wdata[BIT_FLUSH];
    fifo_en = en_q;
    rx_data = rx_stat.empty ? last_q : rx_head;

    ctl_rdata               = '0;
    ctl_rdata[BIT_TX_EMPTY] = tx_stat.empty;
    ctl_rdata[BIT_TX_FULL]  = tx_stat.full;
    ctl_rdata[BIT_TX_IE]    = tx_ie_q;
    ctl_rdata[BIT_RX_EMPTY] = rx_stat.empty;
    ctl_rdata[BIT_RX_FULL]  = rx_stat.full;
    ctl_rdata[BIT_RX_IE]    = rx_ie_q;
    ctl_rdata[BIT_ERR]      = err_q;
    ctl_rdata[BIT_EN]       = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      tx_ie_q  <= 1'b0;
      rx_ie_q  <= 1'b0;
      err_q    <= 1'b0;
      last_q   <= '0;
      irq_tx_q <= 1'b0;
      irq_rx_q <= 1'b0;
    end else begin
      if (cfg_ce) begin
        en_q    <= en_nxt;
        tx_ie_q <= tx_ie_nxt;
        rx_ie_q <= rx_ie_nxt;
      end
      if (err_ce)  err_q  <= err_nxt;
      if (last_ce) last_q <= rx_head;
      irq_tx_q <= irq_tx_nxt;
      irq_rx_q <= irq_rx_nxt;
    end
  end

  assign irq_tx_empty = irq_tx_q;
  assign irq_rx_ready = irq_rx_q;
  assign sink_unused  = ^{tx_stat, rx_stat, ctl_wdata};

  AST_RX_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_q |-> $past(rx_ie_q)); // R5
  AST_TX_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_q |-> $past(tx_ie_q)); // R6
  AST_RX_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_q |=> !irq_rx_q); // R9
  AST_TX_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_q |=> !irq_tx_q); // R9
  AST_ERR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[BIT_ERR] && !tx_stat.push_ovf && !rx_stat.pop_unf)
      |=> !ctl_rdata[BIT_ERR]); // R8
endmodule

// File: rtl/ipcmb_top.sv
module ipcmb_top
  import ipcmb_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_ctl_we,
  input  logic [CTL_W-1:0] a_ctl_wdata,
  output logic [CTL_W-1:0] a_ctl_rdata,
  input  logic             a_tx_valid,
  input  logic [DW-1:0]    a_tx_data,
  input  logic             a_rx_take,
  output logic [DW-1:0]    a_rx_data,
  output logic             a_irq_tx_empty,
  output logic             a_irq_rx_ready,
  input  logic             b_ctl_we,
  input  logic [CTL_W-1:0] b_ctl_wdata,
  output logic [CTL_W-1:0] b_ctl_rdata,
  input  logic             b_tx_valid,
  input  logic [DW-1:0]    b_tx_data,
  input  logic             b_rx_take,
  output logic [DW-1:0]    b_rx_data,
  output logic             b_irq_tx_empty,
  output logic             b_irq_rx_ready
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic          rst_meta, rst_s;
  q_stat_t       ab_stat, ba_stat;
  logic [DW-1:0] ab_head, ba_head;
  logic [CW-1:0] ab_count, ba_count;
  logic          a_en, b_en, a_flush, b_flush;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  ipcmb_queue #(.DW(DW), .DEPTH(DEPTH)) u_q_ab (
    .clk(clk), .rst_n(rst_s),
    .push_req(a_tx_valid & a_en), .push_data(a_tx_data),
    .pop_req(b_rx_take), .flush(a_flush),
    .head(ab_head), .count(ab_count), .stat(ab_stat)
  );

  ipcmb_queue #(.DW(DW), .DEPTH(DEPTH)) u_q_ba (
    .clk(clk), .rst_n(rst_s),
    .push_req(b_tx_valid & b_en), .push_data(b_tx_data),
    .pop_req(a_rx_take), .flush(b_flush),
    .head(ba_head), .count(ba_count), .stat(ba_stat)
  );

  ipcmb_side #(.DW(DW)) u_side_a (
    .clk(clk), .rst_n(rst_s),
    .ctl_we(a_ctl_we), .ctl_wdata(a_ctl_wdata),
    .tx_stat(ab_stat), .rx_stat(ba_stat), .rx_head(ba_head),
    .fifo_en(a_en), .flush(a_flush), .ctl_rdata(a_ctl_rdata),
    .rx_data(a_rx_data), .irq_tx_empty(a_irq_tx_empty), .irq_rx_ready(a_irq_rx_ready)
  );

  ipcmb_side #(.DW(DW)) u_side_b (
    .clk(clk), .rst_n(rst_s),
    .ctl_we(b_ctl_we), .ctl_wdata(b_ctl_wdata),
    .tx_stat(ba_stat), .rx_stat(ab_stat), .rx_head(ab_head),
    .fifo_en(b_en), .flush(b_flush), .ctl_rdata(b_ctl_rdata),
    .rx_data(b_rx_data), .irq_tx_empty(b_irq_tx_empty), .irq_rx_ready(b_irq_rx_ready)
  );

  AST_MIRROR_AB: assert property (@(posedge clk) disable iff (!rst_s)
    (a_ctl_rdata[BIT_TX_EMPTY] == b_ctl_rdata[BIT_RX_EMPTY]) &&
    (a_ctl_rdata[BIT_TX_FULL]  == b_ctl_rdata[BIT_RX_FULL])); // R2
  AST_MIRROR_BA: assert property (@(posedge clk) disable iff (!rst_s)
    (b_ctl_rdata[BIT_TX_EMPTY] == a_ctl_rdata[BIT_RX_EMPTY]) &&
    (b_ctl_rdata[BIT_TX_FULL]  == a_ctl_rdata[BIT_RX_FULL])); // R2
  AST_DISABLED_PUSH_A: assert property (@(posedge clk) disable iff (!rst_s)
    (a_tx_valid && !a_en && !b_rx_take && !a_flush) |=> $stable(ab_count)); // R4
  AST_DISABLED_PUSH_B: assert property (@(posedge clk) disable iff (!rst_s)
    (b_tx_valid && !b_en && !a_rx_take && !b_flush) |=> $stable(ba_count)); // R4
endmodule

// File: tb/sim_ipcmb_top.sv
module sim_ipcmb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Stimulus per side: index 0 = A, 1 = B
  logic        we[2], push[2], take[2];
  logic [15:0] wd[2];
  logic [31:0] pd[2];
  logic [15:0] crd[2];
  logic [31:0] rxd[2];
  logic        itx[2], irx[2];

  // Reference model
  logic [31:0] mbuf[2][16];
  int          mcnt[2];
  logic [31:0] mlast[2];
  bit          men[2], mtie[2], mrie[2], merr[2];

  ipcmb_top u0 (
    .clk(clk), .rst_n(rst_n),
    .a_ctl_we(we[0]), .a_ctl_wdata(wd[0]), .a_ctl_rdata(crd[0]),
    .a_tx_valid(push[0]), .a_tx_data(pd[0]), .a_rx_take(take[0]), .a_rx_data(rxd[0]),
    .a_irq_tx_empty(itx[0]), .a_irq_rx_ready(irx[0]),
    .b_ctl_we(we[1]), .b_ctl_wdata(wd[1]), .b_ctl_rdata(crd[1]),
    .b_tx_valid(push[1]), .b_tx_data(pd[1]), .b_rx_take(take[1]), .b_rx_data(rxd[1]),
    .b_irq_tx_empty(itx[1]), .b_irq_rx_ready(irx[1])
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_ctl(input int s);
    logic [15:0] v = '0;
    v[0]  = (mcnt[s] == 0);
    v[1]  = (mcnt[s] == 16);
    v[2]  = mtie[s];
    v[8]  = (mcnt[1-s] == 0);
    v[9]  = (mcnt[1-s] == 16);
    v[10] = mrie[s];
    v[14] = merr[s];
    v[15] = men[s];
    return v;
  endfunction

  task automatic clear_in();
    for (int s = 0; s < 2; s++) begin
      we[s] = 0; push[s] = 0; take[s] = 0; wd[s] = '0; pd[s] = '0;
    end
  endtask

  // Called just after a falling edge with inputs set; returns after the next falling edge
  task automatic step(input string tag);
    bit eirx[2], eitx[2], es[2];
    #1;
    for (int s = 0; s < 2; s++) begin
      eirx[s] = 0; eitx[s] = 0; es[s] = 0;
    end
    for (int s = 0; s < 2; s++) begin
      int r = 1 - s;
      if (take[r]) chk(tag, "pop data", rxd[r], (mcnt[s] > 0) ? mbuf[s][0] : mlast[r]);
    end
    for (int s = 0; s < 2; s++) begin
      int r = 1 - s;
      int n = mcnt[s];
      bit pok = push[s] && men[s] && (n < 16);
      bit ovf = push[s] && men[s] && (n == 16);
      bit tok = take[r] && (n > 0);
      bit unf = take[r] && (n == 0);
      bit fl  = we[s] && wd[s][3];
      eirx[r] = mrie[r] && (n == 0) && pok && !fl;
      eitx[s] = mtie[s] && (n == 1) && tok && !pok && !fl;
      if (ovf) es[s] = 1;
      if (unf) es[r] = 1;
      if (tok) begin
        mlast[r] = mbuf[s][0];
        for (int k = 0; k < 15; k++) mbuf[s][k] = mbuf[s][k+1];
        mcnt[s]--;
      end
      if (fl) mcnt[s] = 0;
      else if (pok) begin
        mbuf[s][mcnt[s]] = pd[s];
        mcnt[s]++;
      end
    end
    for (int s = 0; s < 2; s++) begin
      if (es[s]) merr[s] = 1;
      else if (we[s] && wd[s][14]) merr[s] = 0;
      if (we[s]) begin
        men[s] = wd[s][15]; mtie[s] = wd[s][2]; mrie[s] = wd[s][10];
      end
    end
    @(posedge clk);
    @(negedge clk);
    clear_in();
    chk(tag, "A ctl", {16'h0, crd[0]}, {16'h0, exp_ctl(0)});
    chk(tag, "B ctl", {16'h0, crd[1]}, {16'h0, exp_ctl(1)});
    chk({tag, " R5"}, "A rx irq", {31'h0, irx[0]}, {31'h0, eirx[0]});
    chk({tag, " R5"}, "B rx irq", {31'h0, irx[1]}, {31'h0, eirx[1]});
    chk({tag, " R6"}, "A tx irq", {31'h0, itx[0]}, {31'h0, eitx[0]});
    chk({tag, " R6"}, "B tx irq", {31'h0, itx[1]}, {31'h0, eitx[1]});
  endtask

  task automatic wr_ctl(input int s, input logic [15:0] v, input string tag);
    we[s] = 1; wd[s] = v; step(tag);
  endtask
  task automatic push_w(input int s, input logic [31:0] v, input string tag);
    push[s] = 1; pd[s] = v; step(tag);
  endtask
  task automatic pop_w(input int s, input string tag);
    take[s] = 1; step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int rnd;
    clear_in();
    for (int s = 0; s < 2; s++) begin
      mcnt[s] = 0; mlast[s] = '0; men[s] = 0; mtie[s] = 0; mrie[s] = 0; merr[s] = 0;
    end
    rnd = $urandom(32'h5EED_0017);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state and R12 layout
    chk("R10", "A rx data", rxd[0], 32'h0);
    chk("R10", "B rx data", rxd[1], 32'h0);
    step("R10");
    // R7 empty pop returns zero and sets error
    pop_w(0, "R7");
    // R8 write with bit14 = 0 keeps error, then write-one clears it
    wr_ctl(0, 16'h8404, "R8");
    wr_ctl(0, 16'hC404, "R8");
    wr_ctl(1, 16'h8404, "R12");
    // R5 first word raises receive-ready at B, then R9 pulse ends
    push_w(0, 32'hA000_0000, "R5");
    step("R9");
    // R1 fill to 16, then overflow is dropped and sets A error
    for (int i = 1; i < 16; i++) push_w(0, 32'hA000_0000 + i, "R1");
    push_w(0, 32'hDEAD_BEEF, "R1");
    step("R2");
    // R11 drain in order, R6 on the last pop
    for (int i = 0; i < 16; i++) pop_w(1, "R11");
    // R7 empty read returns last popped word
    pop_w(1, "R7");
    wr_ctl(0, 16'h4000, "R8");
    wr_ctl(1, 16'h4000, "R8");
    // R4 disabled push discarded
    push_w(0, 32'h1111_1111, "R4");
    pop_w(1, "R4");
    // R3 flush with a push in the same cycle
    wr_ctl(0, 16'h8404, "R3");
    wr_ctl(1, 16'h8404, "R3");
    push_w(0, 32'h2222_0001, "R3");
    push_w(0, 32'h2222_0002, "R3");
    we[0] = 1; wd[0] = 16'h8408; push[0] = 1; pd[0] = 32'h2222_0003; step("R3");
    // R9 push and pop together at one word: no interrupts
    push_w(0, 32'h3333_0001, "R9");
    push[0] = 1; pd[0] = 32'h3333_0002; take[1] = 1; step("R9");
    pop_w(1, "R6");
    // B to A direction
    push_w(1, 32'h4444_0001, "R5");
    pop_w(0, "R11");

    // Random traffic
    for (int c = 0; c < 3000; c++) begin
      for (int s = 0; s < 2; s++) begin
        push[s] = ($urandom % 2) == 0;
        pd[s]   = $urandom;
        take[s] = ($urandom % 5) < 2;
        we[s]   = ($urandom % 20) == 0;
        wd[s]   = 16'($urandom);
        wd[s][15] = ($urandom % 6) != 0;
        wd[s][3]  = ($urandom % 4) == 0;
      end
      step("R11");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule